// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Hold Lock and Timer Interlock

This block shares one memory port among nine requesters: seven I/O channels (slots 0 to 6), an interval-timer updater (slot 8) and the CPU (slot 9). Slot 7 has no requester. Each requester holds `req_valid` high and presents a base address, a byte count, a direction and an access kind. It keeps them steady until its `done` bit pulses. The memory is modelled only as a grant/done handshake. Each byte occupies the port for `CYC_PER_BYTE` cycles, and `mem_addr` steps through the bytes.

Requests are recorded in a pending set. The arbiter serves a separate service queue, scanned in the order held by a rank table. A new request enters the queue at once only when the queue is empty. Otherwise it waits in the pending set until the queue is rebuilt, which happens after each completed access that does not use the hold kind.

A hold access leaves the queue untouched, so its owner stays the only eligible requester. This makes a hold fetch followed by a data store an atomic test-and-set. A timer fetch raises an interlock that keeps the CPU out of the queue until the timer's store completes. Channels are not affected by the interlock.

Top module: `mem_port_arbiter`

## Requirements
- R1: After reset, `gnt`, `done` are all zero and the rank table holds the order 0,1,2,3,4,5,6,8,9 (earliest position wins).
- R2: At most one `gnt` bit is high in any cycle, and accesses never overlap.
- R3: An access of L bytes (L=0 counts as 1) keeps its `gnt` bit high for exactly L*`CYC_PER_BYTE` cycles. `mem_addr` equals base + byte index. Its `done` bit pulses once, in the last granted cycle, and the port is idle in the following cycle.
- R4: Requesters that raise `req_valid` in the same cycle on an idle port are granted in rank order. After a non-hold completion, the next grant goes to the earliest-ranked pending requester, even if it arrived after a lower-ranked one.
- R5: Writing `rank_cfg` (position p in bits [4p+3:4p], holding a slot number) with `rank_wr` high changes the scan order. Channel 0 may sit at any position.
- R6: A rank write is rejected, and the previous order kept, unless it is a permutation of the nine valid slots in which every slot except channel 0 keeps ascending index order.
- R7: After a completed access of the hold kind (`req_kind`=3), no other requester is granted until the same requester completes an access of a non-hold kind (0 data, 1 instruction, 2 fixed).
- R8: After the timer (slot 8) completes a fetch (`req_store`=0), the CPU is not granted until the timer completes a store (`req_store`=1).
- R9: The timer interlock never blocks channel grants.
- R10: A request on slot 7 is never granted and does not disturb other requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 10 | Per-slot request, held until that slot's done pulse |
| req_addr | input | 10*ADDR_W | Per-slot base byte address |
| req_len | input | 10*LEN_W | Per-slot byte count |
| req_store | input | 10 | Per-slot direction: 1 store, 0 fetch |
| req_kind | input | 20 | Per-slot access kind: 0 data, 1 instruction, 2 fixed, 3 hold |
| rank_wr | input | 1 | Load strobe for the rank table |
| rank_cfg | input | 36 | Proposed rank table, nine 4-bit slot numbers |
| gnt | output | 10 | One-hot grant, high for the whole access |
| done | output | 10 | One-cycle pulse on the last granted cycle |
| mem_addr | output | ADDR_W | Address of the byte in progress |
| mem_store | output | 1 | Direction of the access in progress |

## Verification
Every pair of valid slots is raised together on an idle port, which separates a rank-ordered pick from an index-ordered or arrival-ordered pick. Staggered arrivals during a running access show that the queue is rebuilt from the pending set. Rank tables with channel 0 moved are loaded, and then malformed tables are offered whose acceptance would reverse a known pair order. A test-and-set sequence is run with a higher-priority channel waiting, and a timer fetch/store is run with the CPU and a channel waiting, so that a lost lock or a lost interlock shows up in the grant order.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NSLOT  = 10;
  localparam int SLOT_W = 4;
  localparam int NRANK  = 9;
  localparam int TIMER  = 8;
  localparam int CPU    = 9;
  localparam int UNUSED = 7;

  typedef enum logic [1:0] {K_DATA = 2'd0, K_INSTR = 2'd1, K_FIXED = 2'd2, K_HOLD = 2'd3} acc_kind_e;

  // k-th slot (k = 0..7) in ascending order, channel 0 excluded
  function automatic logic [SLOT_W-1:0] ordered_slot(input int k);
    return (k < 6) ? SLOT_W'(k + 1) : SLOT_W'(k + 2);
  endfunction

  function automatic logic [NRANK*SLOT_W-1:0] default_rank();
    logic [NRANK*SLOT_W-1:0] rk;
    rk = '0;
    for (int p = 1; p < NRANK; p++) rk[p*SLOT_W +: SLOT_W] = ordered_slot(p - 1);
    return rk;
  endfunction

  function automatic logic rank_is_valid(input logic [NRANK*SLOT_W-1:0] rk);
    logic ok;
    int   k;
    int   zeros;
    ok = 1'b1;
    k = 0;
    zeros = 0;
    for (int p = 0; p < NRANK; p++) begin
      if (rk[p*SLOT_W +: SLOT_W] == '0) zeros++;
      else begin
        if (k > 7 || rk[p*SLOT_W +: SLOT_W] != ordered_slot(k)) ok = 1'b0;
        k++;
      end
    end
    return ok && (zeros == 1);
  endfunction
endpackage

// File: rtl/rank_reg.sv
module rank_reg
  import arb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [NRANK*SLOT_W-1:0] cfg_rank,
  output logic [NRANK*SLOT_W-1:0] rank_o
);
  logic [NRANK*SLOT_W-1:0] rank_q, rank_d;
  logic                    load_en;

  always_comb begin
    load_en = cfg_wr && rank_is_valid(cfg_rank);
    rank_d  = load_en ? cfg_rank : rank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rank_q <= default_rank();
    else        rank_q <= rank_d;
  end

  assign rank_o = rank_q;

  // R6
  rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) rank_is_valid(rank_q));
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import arb_pkg::*;
(
  input  logic [NRANK*SLOT_W-1:0] rank,
  input  logic [NSLOT-1:0]        queue,
  input  logic [NSLOT-1:0]        pend,
  output logic                    hit,
  output logic [SLOT_W-1:0]       slot
);
  logic found;

  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int p = 0; p < NRANK; p++) begin
      if (!found && queue[rank[p*SLOT_W +: SLOT_W]]) begin
        found = 1'b1;
        slot  = rank[p*SLOT_W +: SLOT_W];
      end
    end
    // head of queue must also be asking (a held owner may be between accesses)
    hit = found && pend[slot];
  end
endmodule

// File: rtl/byte_seq.sv
module byte_seq #(
  parameter int LEN_W        = 4,
  parameter int CYC_PER_BYTE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  output logic             busy,
  output logic [LEN_W-1:0] byte_idx,
  output logic             last
);
  localparam int CYC_W = (CYC_PER_BYTE > 1) ? $clog2(CYC_PER_BYTE) : 1;
  localparam logic [CYC_W-1:0] CYC_END = CYC_W'(CYC_PER_BYTE - 1);

  logic             busy_q, busy_d;
  logic [LEN_W-1:0] byte_q, byte_d, endb_q, endb_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  assign last     = busy_q && (byte_q == endb_q) && (cyc_q == CYC_END);
  assign busy     = busy_q;
  assign byte_idx = byte_q;

  always_comb begin
    busy_d = busy_q;
    byte_d = byte_q;
    endb_d = endb_q;
    cyc_d  = cyc_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        byte_d = '0;
        cyc_d  = '0;
        endb_d = (start_len == '0) ? '0 : start_len - 1'b1;
      end
    end else if (last) begin
      busy_d = 1'b0;
    end else if (cyc_q == CYC_END) begin
      cyc_d  = '0;
      byte_d = byte_q + 1'b1;
    end else begin
      cyc_d  = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      byte_q <= '0;
      endb_q <= '0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      byte_q <= byte_d;
      endb_q <= endb_d;
      cyc_q  <= cyc_d;
    end
  end

  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy_q);
  // R3
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !last) |=> busy_q);
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int LEN_W        = 4,
  parameter int CYC_PER_BYTE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSLOT-1:0]        req_valid,
  input  logic [NSLOT*ADDR_W-1:0] req_addr,
  input  logic [NSLOT*LEN_W-1:0]  req_len,
  input  logic [NSLOT-1:0]        req_store,
  input  logic [NSLOT*2-1:0]      req_kind,
  input  logic                    rank_wr,
  input  logic [NRANK*SLOT_W-1:0] rank_cfg,
  output logic [NSLOT-1:0]        gnt,
  output logic [NSLOT-1:0]        done,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_store
);
  localparam logic [NSLOT-1:0] CPU_BIT    = NSLOT'(1) << CPU;
  localparam logic [NSLOT-1:0] SLOT_USED  = ~(NSLOT'(1) << UNUSED);

  logic                    rs_meta_q, rs_n;
  logic [NRANK*SLOT_W-1:0] rank;
  logic [NSLOT-1:0]        pend_q, pend_d, queue_q, queue_d, arrive;
  logic                    tlock_q, tlock_d;
  logic [SLOT_W-1:0]       own_q, own_d, pick_slot;
  logic [ADDR_W-1:0]       own_addr_q, own_addr_d;
  logic                    own_store_q, own_store_d;
  acc_kind_e               own_kind_q, own_kind_d;
  logic                    pick_hit, start, busy, fin;
  logic [LEN_W-1:0]        byte_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  rank_reg u_rank (
    .clk(clk), .rst_n(rs_n), .cfg_wr(rank_wr), .cfg_rank(rank_cfg), .rank_o(rank)
  );

  prio_pick u_pick (
    .rank(rank), .queue(queue_q), .pend(pend_q), .hit(pick_hit), .slot(pick_slot)
  );

  assign start = !busy && pick_hit;

  byte_seq #(.LEN_W(LEN_W), .CYC_PER_BYTE(CYC_PER_BYTE)) u_seq (
    .clk(clk), .rst_n(rs_n), .start(start),
    .start_len(req_len[pick_slot*LEN_W +: LEN_W]),
    .busy(busy), .byte_idx(byte_idx), .last(fin)
  );

  always_comb begin
    arrive  = req_valid & ~pend_q & SLOT_USED;
    pend_d  = pend_q | arrive;
    tlock_d = tlock_q;
    queue_d = queue_q;
    own_d       = own_q;
    own_addr_d  = own_addr_q;
    own_store_d = own_store_q;
    own_kind_d  = own_kind_q;
    if (fin) begin
      pend_d[own_q] = 1'b0;
      if (own_q == SLOT_W'(TIMER)) tlock_d = !own_store_q;
    end
    if (fin && own_kind_q != K_HOLD) begin
      queue_d = pend_d & ~(tlock_d ? CPU_BIT : '0);
    end else if (queue_q == '0) begin
      queue_d = arrive & ~(tlock_d ? CPU_BIT : '0);
    end
    if (start) begin
      own_d       = pick_slot;
      own_addr_d  = req_addr[pick_slot*ADDR_W +: ADDR_W];
      own_store_d = req_store[pick_slot];
      own_kind_d  = acc_kind_e'(req_kind[pick_slot*2 +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      pend_q      <= '0;
      queue_q     <= '0;
      tlock_q     <= 1'b0;
      own_q       <= '0;
      own_addr_q  <= '0;
      own_store_q <= 1'b0;
      own_kind_q  <= K_DATA;
    end else begin
      pend_q      <= pend_d;
      queue_q     <= queue_d;
      tlock_q     <= tlock_d;
      own_q       <= own_d;
      own_addr_q  <= own_addr_d;
      own_store_q <= own_store_d;
      own_kind_q  <= own_kind_d;
    end
  end

  assign gnt       = busy ? (NSLOT'(1) << own_q) : '0;
  assign done      = fin ? (NSLOT'(1) << own_q) : '0;
  assign mem_addr  = own_addr_q + ADDR_W'(byte_idx);
  assign mem_store = busy && own_store_q;

  // independent lock tracker used only by the checks below
  logic              lk_on_q;
  logic [SLOT_W-1:0] lk_slot_q;
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      lk_on_q   <= 1'b0;
      lk_slot_q <= '0;
    end else if (fin) begin
      if (own_kind_q == K_HOLD) begin
        lk_on_q   <= 1'b1;
        lk_slot_q <= own_q;
      end else if (own_q == lk_slot_q) begin
        lk_on_q   <= 1'b0;
      end
    end
  end

  // R7
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (start && lk_on_q) |-> (pick_slot == lk_slot_q));
  // R8
  cpu_fenced_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (start && tlock_q) |-> (pick_slot != SLOT_W'(CPU)));
  // R3
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (done != '0) |=> (gnt == '0));
  // R10
  no_slot7_chk: assert property (@(posedge clk) disable iff (!rs_n) !gnt[UNUSED]);
  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rs_n) $onehot0(gnt));
endmodule

// File: tb/mem_port_arbiter_test.sv
module mem_port_arbiter_test;
  import arb_pkg::*;
  localparam int AW = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NSLOT-1:0]        rv;
  logic [NSLOT*AW-1:0]     addr_p;
  logic [NSLOT*LW-1:0]     len_p;
  logic [NSLOT-1:0]        st_p;
  logic [NSLOT*2-1:0]      kind_p;
  logic                    rank_wr = 1'b0;
  logic [NRANK*SLOT_W-1:0] rank_cfg = '0;
  logic [NSLOT-1:0]        gnt, done;
  logic [AW-1:0]           mem_addr;
  logic                    mem_store;

  logic [AW-1:0] ba [NSLOT];
  logic [LW-1:0] bl [NSLOT];
  logic          bs [NSLOT];
  logic [1:0]    bk [NSLOT];
  logic          nv [NSLOT];
  logic          ns [NSLOT];
  logic [1:0]    nk [NSLOT];

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      addr_p[i*AW +: AW] = ba[i];
      len_p[i*LW +: LW]  = bl[i];
      st_p[i]            = bs[i];
      kind_p[i*2 +: 2]   = bk[i];
    end
  end

  mem_port_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_addr(addr_p), .req_len(len_p),
    .req_store(st_p), .req_kind(kind_p), .rank_wr(rank_wr), .rank_cfg(rank_cfg),
    .gnt(gnt), .done(done), .mem_addr(mem_addr), .mem_store(mem_store)
  );

  int n_chk = 0, n_bad = 0;
  int lg [64];
  int lgn = 0;
  logic [NSLOT-1:0] prev_gnt = '0;
  int ovl_err = 0, lock_err = 0, cpu_err = 0, g7 = 0;
  logic lk = 1'b0, tw = 1'b0;
  int lks = 0;
  int g9cyc = 0, d9cnt = 0;
  logic [AW-1:0] a9first = '0, a9last = '0;
  logic finished = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!$onehot0(gnt)) ovl_err++;
    if (gnt[UNUSED]) g7++;
    if (gnt[CPU]) g9cyc++;
    for (int i = 0; i < NSLOT; i++) begin
      if (gnt[i] && !prev_gnt[i]) begin
        if (lgn < 64) lg[lgn] = i;
        lgn++;
        if (lk && i != lks) lock_err++;
        if (tw && i == CPU) cpu_err++;
        if (i == CPU) a9first = mem_addr;
      end
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (done[i]) begin
        if (i == CPU) begin d9cnt++; a9last = mem_addr; end
        if (bk[i] == 2'd3) begin lk = 1'b1; lks = i; end
        else if (lk && lks == i) lk = 1'b0;
        if (i == TIMER) tw = !bs[i];
        if (nv[i]) begin
          bs[i] = ns[i]; bk[i] = nk[i]; nv[i] = 1'b0;
        end else rv[i] = 1'b0;
      end
    end
    prev_gnt = gnt;
  endtask

  task automatic raise(input int s, input int a, input int l, input logic st, input logic [1:0] k);
    ba[s] = AW'(a); bl[s] = LW'(l); bs[s] = st; bk[s] = k; rv[s] = 1'b1;
  endtask

  task automatic settle();
    for (int n = 0; n < 2000 && (rv != '0 || gnt != '0); n++) step();
    for (int n = 0; n < 3; n++) step();
  endtask

  task automatic clr_log();
    lgn = 0;
    for (int i = 0; i < 64; i++) lg[i] = -1;
  endtask

  task automatic load_rank(input int o0, input int o1, input int o2, input int o3, input int o4,
                           input int o5, input int o6, input int o7, input int o8);
    rank_cfg = {SLOT_W'(o8), SLOT_W'(o7), SLOT_W'(o6), SLOT_W'(o5), SLOT_W'(o4),
                SLOT_W'(o3), SLOT_W'(o2), SLOT_W'(o1), SLOT_W'(o0)};
    rank_wr = 1'b1;
    step();
    rank_wr = 1'b0;
    step();
  endtask

  // raise two slots together on an idle port, return who went first
  task automatic pair(input int a, input int b, output int first);
    clr_log();
    raise(a, 16 * a, 1, 1'b1, 2'd0);
    raise(b, 16 * b, 1, 1'b1, 2'd0);
    settle();
    first = lg[0];
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int slots [9];
    int f;
    slots = '{0, 1, 2, 3, 4, 5, 6, 8, 9};
    rv = '0;
    for (int i = 0; i < NSLOT; i++) begin
      ba[i] = '0; bl[i] = '0; bs[i] = 1'b0; bk[i] = 2'd0; nv[i] = 1'b0; ns[i] = 1'b0; nk[i] = 2'd0;
    end
    clr_log();
    for (int n = 0; n < 3; n++) step();
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) step();

    // R1 reset state
    chk(gnt == '0, "R1 gnt", int'(gnt), 0);
    chk(done == '0, "R1 done", int'(done), 0);

    // R3 CPU access of 3 bytes at 0x100: 6 granted cycles
    g9cyc = 0; d9cnt = 0;
    raise(CPU, 'h100, 3, 1'b0, 2'd0);
    settle();
    chk(g9cyc == 6, "R3 grant length", g9cyc, 6);
    chk(d9cnt == 1, "R3 done pulses", d9cnt, 1);
    chk(a9first == 'h100, "R3 first addr", int'(a9first), 'h100);
    chk(a9last == 'h102, "R3 last addr", int'(a9last), 'h102);
    // R3 zero length counts as one byte
    g9cyc = 0;
    raise(CPU, 'h20, 0, 1'b0, 2'd0);
    settle();
    chk(g9cyc == 2, "R3 zero length", g9cyc, 2);

    // R4 sweep over all pairs with the default rank (R1 order)
    for (int x = 0; x < 9; x++)
      for (int y = x + 1; y < 9; y++) begin
        pair(slots[x], slots[y], f);
        chk(f == slots[x], "R4 pair order", f, slots[x]);
        chk(lgn == 2, "R4 pair grants", lgn, 2);
      end

    // R4 late higher-ranked arrival overtakes earlier pending CPU
    clr_log();
    raise(5, 'h50, 2, 1'b0, 2'd0);
    step(); step();
    raise(CPU, 'h90, 1, 1'b0, 2'd0);
    step();
    raise(1, 'h10, 1, 1'b0, 2'd0);
    settle();
    chk(lg[0] == 5 && lg[1] == 1 && lg[2] == 9, "R4 pending order", lg[1], 1);

    // R10 slot 7 never granted, CPU unaffected
    clr_log();
    raise(UNUSED, 'h70, 1, 1'b0, 2'd0);
    raise(CPU, 'h90, 1, 1'b0, 2'd0);
    for (int n = 0; n < 20; n++) step();
    chk(lgn == 1 && lg[0] == CPU, "R10 slot7 ignored", lgn, 1);
    rv[UNUSED] = 1'b0;
    settle();

    // R7 test-and-set: hold fetch then data store, channel 2 waiting
    clr_log();
    raise(CPU, 'h40, 1, 1'b0, 2'd3);
    nv[CPU] = 1'b1; ns[CPU] = 1'b1; nk[CPU] = 2'd0;
    step();
    raise(2, 'h22, 1, 1'b0, 2'd0);
    settle();
    chk(lg[0] == 9 && lg[1] == 9 && lg[2] == 2, "R7 hold order", lg[1], 9);

    // R8/R9 timer fetch, CPU and channel 4 waiting, store later
    clr_log();
    raise(TIMER, 'h80, 1, 1'b0, 2'd2);
    step();
    raise(CPU, 'h90, 1, 1'b0, 2'd0);
    raise(4, 'h44, 1, 1'b0, 2'd0);
    for (int n = 0; n < 200 && rv[4]; n++) step();
    for (int n = 0; n < 8; n++) step();
    chk(lgn == 2 && lg[1] == 4, "R9 channel during interlock", lg[1], 4);
    chk(rv[CPU] == 1'b1 && lgn == 2, "R8 cpu held off", lgn, 2);
    raise(TIMER, 'h80, 1, 1'b1, 2'd2);
    settle();
    chk(lg[2] == TIMER && lg[3] == CPU, "R8 cpu after timer store", lg[3], CPU);

    // R5 channel 0 last
    load_rank(1, 2, 3, 4, 5, 6, 8, 9, 0);
    pair(0, CPU, f);
    chk(f == CPU, "R5 ch0 last", f, CPU);
    // R5 channel 0 in third position
    load_rank(1, 2, 0, 3, 4, 5, 6, 8, 9);
    pair(0, 3, f);
    chk(f == 0, "R5 ch0 before ch3", f, 0);
    pair(0, 1, f);
    chk(f == 1, "R5 ch1 before ch0", f, 1);
    // R6 broken order rejected: would put ch3 before ch0
    load_rank(1, 2, 3, 4, 0, 5, 6, 9, 8);
    pair(0, 3, f);
    chk(f == 0, "R6 order break rejected", f, 0);
    // R6 duplicate rejected
    load_rank(1, 2, 3, 4, 0, 5, 6, 8, 8);
    pair(0, 3, f);
    chk(f == 0, "R6 duplicate rejected", f, 0);

    chk(ovl_err == 0, "R2 overlap", ovl_err, 0);
    chk(lock_err == 0, "R7 lock breach", lock_err, 0);
    chk(cpu_err == 0, "R8 interlock breach", cpu_err, 0);
    chk(g7 == 0, "R10 slot7 grants", g7, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule